// File: doc/BRIEF.md
# Triggered Glitch Pulse Generator

This block produces a single timed disturbance pulse in response to an external trigger signal. The host first programs five runtime settings: which trigger edge counts, the idle level of the output, how many qualifying edges to wait for, how many clock cycles to wait after the last of them, and how many clock cycles the pulse lasts. The host then pulses arm. The block counts qualifying trigger edges. After the final counted edge it waits the programmed delay, drives the glitch line to its active level for the programmed width, and then stops in a finished state. A typical use is gating a switching transistor that briefly disturbs a supply rail, with a host that sweeps delay and width between attempts without rebuilding the hardware. All timing is in cycles of the system clock, about 50 MHz.

The controller is a state machine with five states: IDLE (waiting for arm), ARMED (counting edges), DELAY (waiting before the pulse), GLITCH (pulse active) and DONE (finished, waiting for re-arm). The transitions are named as follows. Arm-accept goes from IDLE or DONE to ARMED. Last-edge leaves ARMED for DELAY, or for GLITCH when the delay is zero, or for DONE when both delay and width are zero. Delay-expiry leaves DELAY for GLITCH, or for DONE when the width is zero. Pulse-end goes from GLITCH to DONE. Abort goes from any state to IDLE.

Top module: `glitch_pulse_gen`

## Requirements
- R1: The trigger passes through a two-flop synchronizer. The qualifying edge is rising when `cfg_trig_fall_i` is 0 and falling when it is 1. Edges of the other sense have no effect.
- R2: After arming, the block waits for `cfg_edge_count_i` qualifying edges before it leaves ARMED. A count of 0 behaves as 1. No pulse appears before the final counted edge.
- R3: With a captured delay D, the glitch first shows its active level 3 + D clock cycles after the trigger input changes at the final counted edge. With D = 0, GLITCH is entered on the cycle after the synchronized edge is detected.
- R4: With a captured width W > 0, the output holds its active level for exactly W consecutive cycles. With W = 0, no pulse appears and the block goes straight to DONE.
- R5: The active level is 1 when `cfg_glitch_low_i` is 0 and 0 when it is 1. Whenever no pulse is in progress, the output rests at the opposite level. While not busy, the idle level follows the setting.
- R6: All settings are captured on the cycle arm is accepted. Changes to the settings while busy have no effect on the current run, and an arm pulse while busy is ignored.
- R7: Each arming yields at most one pulse. DONE holds, ignoring further trigger edges, until the next arm or abort.
- R8: An abort returns the block to IDLE from any state. On the following cycle busy and done are 0 and the output is at its idle level.
- R9: `busy_o` is 1 in ARMED, DELAY and GLITCH. `done_o` is 1 only in DONE. The two are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| abort_i | input | 1 | Return to IDLE from any state |
| arm_i | input | 1 | Start a run; accepted in IDLE or DONE |
| trig_i | input | 1 | Asynchronous external trigger |
| cfg_trig_fall_i | input | 1 | 0: rising edges qualify, 1: falling edges qualify |
| cfg_glitch_low_i | input | 1 | 0: active-high pulse, 1: active-low pulse |
| cfg_edge_count_i | input | CNT_W | Qualifying edges to wait for (0 acts as 1) |
| cfg_delay_i | input | DLY_W | Cycles from the last counted edge to the pulse |
| cfg_width_i | input | WID_W | Pulse length in cycles |
| glitch_o | output | 1 | Glitch drive line |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished |

## Verification
The assertions watch invariants that hold on every cycle. Busy and done are never both set. An abort leaves the block idle at the idle level one cycle later. The captured settings and the polarity stay frozen while busy. GLITCH is entered only from ARMED or DELAY. DONE holds until arm or abort, and the timers never underflow. The exact arithmetic can only be shown by the bench's scenarios: the 3 + D start latency, the W-cycle width, edge counting with ignored opposite-sense edges, zero-count and zero-width handling, and one pulse per arming. These are checked over every combination of edge sense, polarity, count 0 to 3, delay 0 to 3 and width 0 to 3, and by directed runs that change the settings mid-run and abort in different states.

// File: rtl/glitch_pkg.sv
package glitch_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ARMED  = 3'd1,
        ST_DELAY  = 3'd2,
        ST_GLITCH = 3'd3,
        ST_DONE   = 3'd4
    } gl_state_t;

endpackage

// File: rtl/gl_edge_sync.sv
module gl_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    input  logic fall_sel_i,
    output logic edge_o
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    logic              cur;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[0] <= 1'b0;
                else        chain_q[0] <= sig_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[i] <= 1'b0;
                else        chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign cur = chain_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= cur;
    end

    always_comb begin
        if (fall_sel_i) edge_o = prev_q & ~cur;
        else            edge_o = cur & ~prev_q;
    end

endmodule

// File: rtl/gl_down_counter.sv
module gl_down_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic [W-1:0] cnt_o,
    output logic         last_o
);

    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_o <= '0;
        else if (load_i) cnt_o <= load_val_i;
        else if (dec_i)  cnt_o <= cnt_o - ONE;
    end

    assign last_o = (cnt_o == ONE);

    // R2 R3 R4: a decrement never wraps below zero
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i) |-> (cnt_o != '0));

endmodule

// File: rtl/glitch_pulse_gen.sv
module glitch_pulse_gen
    import glitch_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int DLY_W       = 16,
    parameter int WID_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort_i,
    input  logic             arm_i,
    input  logic             trig_i,
    input  logic             cfg_trig_fall_i,
    input  logic             cfg_glitch_low_i,
    input  logic [CNT_W-1:0] cfg_edge_count_i,
    input  logic [DLY_W-1:0] cfg_delay_i,
    input  logic [WID_W-1:0] cfg_width_i,
    output logic             glitch_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam int TMR_W = (DLY_W > WID_W) ? DLY_W : WID_W;

    gl_state_t         state_q, state_nx;
    logic [DLY_W-1:0]  cap_delay_q;
    logic [WID_W-1:0]  cap_width_q;
    logic              cap_fall_q;
    logic              pol_low_q;
    logic              trig_edge;
    logic              arm_go;
    logic [CNT_W-1:0]  edge_load_val;
    logic              edge_dec;
    logic [CNT_W-1:0]  edge_left;
    logic              edge_last;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_load_val;
    logic              tmr_dec;
    logic [TMR_W-1:0]  tmr_cnt;
    logic              tmr_last;
    logic              in_run;

    // ---------------- trigger synchronizer and edge select
    gl_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .sig_i      (trig_i),
        .fall_sel_i (cap_fall_q),
        .edge_o     (trig_edge)
    );

    // ---------------- arm acceptance and capture
    assign arm_go = arm_i && !abort_i &&
                    (state_q == ST_IDLE || state_q == ST_DONE);
    assign in_run = (state_q == ST_ARMED) || (state_q == ST_DELAY) ||
                    (state_q == ST_GLITCH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_delay_q <= '0;
            cap_width_q <= '0;
            cap_fall_q  <= 1'b0;
        end else if (arm_go) begin
            cap_delay_q <= cfg_delay_i;
            cap_width_q <= cfg_width_i;
            cap_fall_q  <= cfg_trig_fall_i;
        end
    end

    // idle level tracks the setting whenever no run is in progress
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pol_low_q <= 1'b0;
        else if (!in_run) pol_low_q <= cfg_glitch_low_i;
    end

    // ---------------- edge counter
    assign edge_load_val = (cfg_edge_count_i == '0) ? CNT_W'(1) : cfg_edge_count_i;
    assign edge_dec      = (state_q == ST_ARMED) && trig_edge && !abort_i;

    gl_down_counter #(.W(CNT_W)) u_edge_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (arm_go),
        .load_val_i (edge_load_val),
        .dec_i      (edge_dec),
        .cnt_o      (edge_left),
        .last_o     (edge_last)
    );

    // ---------------- delay / width timer
    always_comb begin
        tmr_load     = 1'b0;
        tmr_load_val = '0;
        if (state_nx == ST_DELAY && state_q != ST_DELAY) begin
            tmr_load     = 1'b1;
            tmr_load_val = TMR_W'(cap_delay_q);
        end else if (state_nx == ST_GLITCH && state_q != ST_GLITCH) begin
            tmr_load     = 1'b1;
            tmr_load_val = TMR_W'(cap_width_q);
        end
    end

    assign tmr_dec = (state_q == ST_DELAY) || (state_q == ST_GLITCH);

    gl_down_counter #(.W(TMR_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_load_val),
        .dec_i      (tmr_dec),
        .cnt_o      (tmr_cnt),
        .last_o     (tmr_last)
    );

    // ---------------- state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // ---------------- next-state logic
    always_comb begin
        state_nx = state_q;
        if (abort_i) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (arm_i) state_nx = ST_ARMED;
                end
                ST_ARMED: begin
                    if (trig_edge && edge_last) begin
                        if (cap_delay_q != '0)      state_nx = ST_DELAY;
                        else if (cap_width_q != '0) state_nx = ST_GLITCH;
                        else                        state_nx = ST_DONE;
                    end
                end
                ST_DELAY: begin
                    if (tmr_last) begin
                        if (cap_width_q != '0) state_nx = ST_GLITCH;
                        else                   state_nx = ST_DONE;
                    end
                end
                ST_GLITCH: begin
                    if (tmr_last) state_nx = ST_DONE;
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // ---------------- outputs
    always_comb begin
        glitch_o = pol_low_q;
        busy_o   = 1'b0;
        done_o   = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ARMED:  busy_o = 1'b1;
            ST_DELAY:  busy_o = 1'b1;
            ST_GLITCH: begin
                busy_o   = 1'b1;
                glitch_o = ~pol_low_q;
            end
            ST_DONE:   done_o = 1'b1;
            default:   ;
        endcase
    end

    // ---------------- assertions
    p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!busy_o && !done_o && glitch_o == pol_low_q));

    p_capture_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !abort_i) |=> ($stable(cap_delay_q) && $stable(cap_width_q) &&
                                  $stable(cap_fall_q)));

    p_polarity_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(pol_low_q));

    p_glitch_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_GLITCH) |->
            ($past(state_q) == ST_ARMED || $past(state_q) == ST_DELAY));

    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !arm_i && !abort_i) |=> done_o);

    p_edges_left_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED) |-> (edge_left != '0));

    p_timer_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GLITCH) |-> (tmr_cnt != '0));

endmodule

// File: tb/sim_glitch_pulse_gen.sv
module sim_glitch_pulse_gen;

    localparam int CW = 8;
    localparam int DW = 16;
    localparam int WW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          abort_i, arm_i, trig_i;
    logic          cfg_trig_fall_i, cfg_glitch_low_i;
    logic [CW-1:0] cfg_edge_count_i;
    logic [DW-1:0] cfg_delay_i;
    logic [WW-1:0] cfg_width_i;
    logic          glitch_o, busy_o, done_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    glitch_pulse_gen #(.CNT_W(CW), .DLY_W(DW), .WID_W(WW)) u0 (
        .clk              (clk),
        .rst_n            (rst_n),
        .abort_i          (abort_i),
        .arm_i            (arm_i),
        .trig_i           (trig_i),
        .cfg_trig_fall_i  (cfg_trig_fall_i),
        .cfg_glitch_low_i (cfg_glitch_low_i),
        .cfg_edge_count_i (cfg_edge_count_i),
        .cfg_delay_i      (cfg_delay_i),
        .cfg_width_i      (cfg_width_i),
        .glitch_o         (glitch_o),
        .busy_o           (busy_o),
        .done_o           (done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic pulse_arm();
        arm_i = 1'b1;
        @(negedge clk);
        arm_i = 1'b0;
    endtask

    // drives the final edge already set by caller, then watches 40 cycles
    task automatic watch(input bit tp, input bit gp, output int first, output int len);
        first = -1;
        len   = 0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (glitch_o != gp) begin
                if (first < 0) first = k;
                len++;
            end
            if (k == 4)  trig_i = tp;
            if (k == 20) trig_i = !tp;
            if (k == 24) trig_i = tp;
        end
    endtask

    task automatic run_case(input bit tp, input bit gp, input int cnt, input int d, input int w);
        int eff, early, first, len;
        cfg_trig_fall_i  = tp;
        cfg_glitch_low_i = gp;
        cfg_edge_count_i = CW'(cnt);
        cfg_delay_i      = DW'(d);
        cfg_width_i      = WW'(w);
        trig_i           = tp;
        repeat (4) @(negedge clk);
        check(glitch_o == gp, "R5 idle level before arm", int'(glitch_o), int'(gp));
        pulse_arm();
        @(negedge clk);
        check(busy_o && !done_o, "R9 busy while armed", int'({busy_o, done_o}), 2);
        eff   = (cnt == 0) ? 1 : cnt;
        early = 0;
        for (int e = 0; e < eff - 1; e++) begin
            trig_i = !tp;
            repeat (4) begin @(negedge clk); if (glitch_o != gp) early++; end
            trig_i = tp;
            repeat (4) begin @(negedge clk); if (glitch_o != gp) early++; end
        end
        check(early == 0, "R2 no pulse before final counted edge", early, 0);
        trig_i = !tp;
        watch(tp, gp, first, len);
        if (w == 0) begin
            check(len == 0, "R4 zero width gives no pulse", len, 0);
        end else begin
            check(first == 3 + d, "R1 R3 pulse start latency", first, 3 + d);
            check(len == w, "R4 R7 pulse width and single pulse", len, w);
        end
        check(done_o && !busy_o, "R7 R9 done holds after run", int'({busy_o, done_o}), 1);
    endtask

    initial begin
        int first, len;
        rst_n = 1'b0; abort_i = 1'b0; arm_i = 1'b0; trig_i = 1'b0;
        cfg_trig_fall_i = 1'b0; cfg_glitch_low_i = 1'b0;
        cfg_edge_count_i = '0; cfg_delay_i = '0; cfg_width_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && glitch_o == 1'b0, "R9 reset state",
              int'({glitch_o, busy_o, done_o}), 0);

        // near-exhaustive sweep of small settings
        for (int tp = 0; tp < 2; tp++)
            for (int gp = 0; gp < 2; gp++)
                for (int c = 0; c < 4; c++)
                    for (int d = 0; d < 4; d++)
                        for (int w = 0; w < 4; w++)
                            run_case(tp[0], gp[0], c, d, w);

        // R6: settings changed and arm pulsed while busy
        cfg_trig_fall_i = 1'b0; cfg_glitch_low_i = 1'b0;
        cfg_edge_count_i = CW'(1); cfg_delay_i = DW'(2); cfg_width_i = WW'(2);
        trig_i = 1'b0;
        repeat (4) @(negedge clk);
        pulse_arm();
        cfg_delay_i = DW'(7); cfg_width_i = WW'(5);
        cfg_trig_fall_i = 1'b1; cfg_edge_count_i = CW'(3);
        @(negedge clk);
        pulse_arm();
        @(negedge clk);
        trig_i = 1'b1;
        watch(1'b0, 1'b0, first, len);
        check(first == 5, "R6 start uses captured delay", first, 5);
        check(len == 2, "R6 width uses captured width", len, 2);

        // R8: abort during GLITCH
        cfg_trig_fall_i = 1'b0; cfg_glitch_low_i = 1'b1;
        cfg_edge_count_i = CW'(1); cfg_delay_i = DW'(10); cfg_width_i = WW'(10);
        trig_i = 1'b0;
        repeat (4) @(negedge clk);
        pulse_arm();
        @(negedge clk);
        trig_i = 1'b1;
        repeat (15) @(negedge clk);
        check(glitch_o == 1'b0, "R3 R5 active-low pulse in progress", int'(glitch_o), 0);
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        check(glitch_o == 1'b1 && !busy_o && !done_o, "R8 abort during pulse",
              int'({glitch_o, busy_o, done_o}), 4);
        len = 0;
        repeat (20) begin @(negedge clk); if (glitch_o != 1'b1) len++; end
        check(len == 0 && !done_o, "R8 no pulse after abort", len, 0);

        // R8: abort during ARMED, later edges ignored
        trig_i = 1'b0;
        repeat (4) @(negedge clk);
        pulse_arm();
        @(negedge clk);
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        check(!busy_o && !done_o, "R8 abort while armed", int'({busy_o, done_o}), 0);
        trig_i = 1'b1;
        len = 0;
        repeat (30) begin @(negedge clk); if (glitch_o != 1'b1) len++; end
        check(len == 0 && !busy_o, "R8 idle after abort ignores trigger", len, 0);

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            summary();
            $finish;
        end
    end

endmodule